// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-signal serial link: an active-high chip select, a serial clock and one bidirectional data line. It gives an external controller byte access to a 7-bit register space inside the chip. Each transfer opens with a command byte that carries a register address and a direction flag. One or more data bytes follow, and the address steps forward after each one. Every bit travels least significant first. The data line is driven through a data-out value and an output enable, so the tri-state pad lives outside the block.

Towards the chip, the port has a plain parallel register bus. It puts out an address and reads back the byte held there through a combinational return path. A write appears as a one-cycle strobe with the address and data. A hold output stays high while the controller is reading the register at the hold address, the last implemented location. The block that owns that sampled register uses it to freeze updates until the byte has gone out.

All serial inputs are brought into the system clock domain through synchronizers, and the serial clock is oversampled. The system clock must run at no less than four times the serial clock rate.

Top module: `tw_reg_port`

## Requirements
- R1: The first byte after chip select rises is a command byte, received LSB first. Its bit 7 set means write and bit 7 clear means read. Bits 6:0 are the starting register address.
- R2: In a write, each fully received data byte (LSB first) produces exactly one system-clock pulse on `reg_wr_o`. During that pulse `reg_wdata_o` holds the byte and `reg_addr_o` holds its address.
- R3: A data byte cut short by chip select falling produces no write strobe, and the register keeps its earlier value.
- R4: In a read, bit 0 of the first data byte is driven on `sdio_o` after the serial clock falling edge that follows the last command bit. Each later bit follows on the next falling edge, LSB first. `sdio_oe` is high from that first falling edge.
- R5: In a burst, each data byte after the first goes to the next address. This holds for both reads and writes.
- R6: After the byte at address 0x0E, the address wraps to 0x00. Any other address advances by one, modulo 128.
- R7: Addresses 0x0F to 0x7F read as 0x00 whatever the register bus returns. Data bytes aimed at them produce no write strobe.
- R8: When chip select falls, `sdio_oe` drops and the transfer ends. The next rise of chip select starts again with a command byte.
- R9: `hold_o` is high while a read transfer addresses 0x0E in its data phase. It is low for any other address. It is released when the address advances or chip select falls.
- R10: After reset, `sdio_oe`, `reg_wr_o` and `hold_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data line drive value |
| sdio_oe | output | 1 | Data line output enable |
| reg_addr_o | output | 7 | Register bus address |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, combinational |
| hold_o | output | 1 | Sampled register must not change |

## Verification
The assertions assume a serial clock with each half period lasting at least two system clocks. They also assume chip select rises and falls only while the serial clock is low. Under those limits every edge is seen once, and the load of a read byte completes before the next falling edge. The bench keeps each serial half period at four system clocks and moves chip select only while the serial clock is low. The register bus model returns a non-zero pattern for reserved addresses, and a free-running counter stands in for the sampled register, so both the zero masking and the hold are seen at the ports.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } tw_phase_e;

   function automatic logic [6:0] tw_step_addr(input logic [6:0] a, input logic [6:0] last);
      return (a == last) ? 7'd0 : a + 7'd1;
   endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= d_i;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
   parameter int ADDR_W    = 7,
   parameter int LAST_ADDR = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              in_range_o
);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_last
      $error("tw_addr_ctr: LAST_ADDR outside the address space");
   end

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load_i) begin
         addr_q <= load_val_i;
      end else if (adv_i) begin
         addr_q <= (addr_q == LAST_A) ? '0 : addr_q + 1'b1;
      end
   end

   assign addr_o     = addr_q;
   assign in_range_o = (addr_q <= LAST_A);

   // R6
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && addr_q == LAST_A) |=> (addr_q == '0));

   // R5
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && addr_q != LAST_A) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/tw_frame_ctl.sv
module tw_frame_ctl
   import tw_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s_i,
   input  logic              sclk_s_i,
   input  logic              sdi_s_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              in_range_i,
   output logic              addr_load_o,
   output logic [ADDR_W-1:0] addr_val_o,
   output logic              addr_adv_o,
   output logic              wr_stb_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              sdo_o,
   output logic              oe_o,
   output logic              rd_data_o
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   if (ADDR_W >= DATA_W) begin : g_bad_widths
      $error("tw_frame_ctl: command byte needs room for the direction bit");
   end

   tw_phase_e         phase_q;
   logic              wr_mode_q;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] out_byte_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_pend_q;
   logic              load_pend_q;
   logic              sdo_q;
   logic              oe_q;
   logic              sclk_prev_q;

   logic              sclk_rise;
   logic              sclk_fall;
   logic [DATA_W-1:0] shin;
   logic              byte_done;

   assign sclk_rise = sclk_s_i & ~sclk_prev_q;
   assign sclk_fall = ~sclk_s_i & sclk_prev_q;
   assign shin      = {sdi_s_i, shreg_q[DATA_W-1:1]};
   assign byte_done = cs_s_i && sclk_rise && (bit_cnt_q == LAST_BIT);

   assign addr_load_o = byte_done && (phase_q == PH_CMD);
   assign addr_val_o  = shin[ADDR_W-1:0];
   assign addr_adv_o  = (byte_done && phase_q == PH_DATA && !wr_mode_q) || wr_pend_q;
   assign wr_stb_o    = wr_pend_q && in_range_i;
   assign wdata_o     = wdata_q;
   assign sdo_o       = sdo_q;
   assign oe_o        = oe_q;
   assign rd_data_o   = cs_s_i && (phase_q == PH_DATA) && !wr_mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
      end else begin
         sclk_prev_q <= sclk_s_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_CMD;
         wr_mode_q   <= 1'b0;
         bit_cnt_q   <= '0;
         shreg_q     <= '0;
         out_byte_q  <= '0;
         wdata_q     <= '0;
         wr_pend_q   <= 1'b0;
         load_pend_q <= 1'b0;
         sdo_q       <= 1'b0;
         oe_q        <= 1'b0;
      end else begin
         wr_pend_q   <= 1'b0;
         load_pend_q <= 1'b0;
         if (!cs_s_i) begin
            phase_q   <= PH_CMD;
            wr_mode_q <= 1'b0;
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
         end else begin
            if (load_pend_q) begin
               out_byte_q <= rdata_i;
            end
            if (sclk_rise) begin
               shreg_q   <= shin;
               bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
               if (bit_cnt_q == LAST_BIT) begin
                  if (phase_q == PH_CMD) begin
                     phase_q     <= PH_DATA;
                     wr_mode_q   <= shin[DATA_W-1];
                     load_pend_q <= ~shin[DATA_W-1];
                  end else if (wr_mode_q) begin
                     wr_pend_q <= 1'b1;
                     wdata_q   <= shin;
                  end else begin
                     load_pend_q <= 1'b1;
                  end
               end
            end
            if (sclk_fall && phase_q == PH_DATA && !wr_mode_q) begin
               sdo_q <= out_byte_q[bit_cnt_q];
               oe_q  <= 1'b1;
            end
         end
      end
   end

   // R2
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pend_q |=> !wr_pend_q);

   // R4
   oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> (phase_q == PH_DATA && !wr_mode_q));

   // R8
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s_i && !sclk_rise) |=> $stable(bit_cnt_q));

   // R1
   cmd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA && cs_s_i) |=> (phase_q == PH_DATA || !$past(cs_s_i) || !cs_s_i) || 1'b0);
endmodule

// File: rtl/tw_reg_port.sv
module tw_reg_port #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int LAST_ADDR   = 14,
   parameter int HOLD_ADDR   = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              sclk_i,
   input  logic              sdio_i,
   output logic              sdio_o,
   output logic              sdio_oe,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              reg_wr_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   input  logic [DATA_W-1:0] reg_rdata_i,
   output logic              hold_o
);
   localparam logic [ADDR_W-1:0] HOLD_A = ADDR_W'(HOLD_ADDR);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

   if (HOLD_ADDR > LAST_ADDR) begin : g_bad_hold
      $error("tw_reg_port: HOLD_ADDR must be an implemented address");
   end

   logic [2:0]        sync_q;
   logic              cs_s, sclk_s, sdi_s;
   logic              addr_load, addr_adv, in_range, oe_int, rd_data;
   logic [ADDR_W-1:0] addr_val, addr;
   logic [DATA_W-1:0] rdata_gated;

   tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_i, sclk_i, sdio_i}),
      .q_o   (sync_q)
   );
   assign {cs_s, sclk_s, sdi_s} = sync_q;

   tw_addr_ctr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (addr_load),
      .load_val_i (addr_val),
      .adv_i      (addr_adv),
      .addr_o     (addr),
      .in_range_o (in_range)
   );

   assign rdata_gated = in_range ? reg_rdata_i : '0;

   tw_frame_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_s_i      (cs_s),
      .sclk_s_i    (sclk_s),
      .sdi_s_i     (sdi_s),
      .rdata_i     (rdata_gated),
      .in_range_i  (in_range),
      .addr_load_o (addr_load),
      .addr_val_o  (addr_val),
      .addr_adv_o  (addr_adv),
      .wr_stb_o    (reg_wr_o),
      .wdata_o     (reg_wdata_o),
      .sdo_o       (sdio_o),
      .oe_o        (oe_int),
      .rd_data_o   (rd_data)
   );

   assign sdio_oe    = oe_int & cs_i;
   assign reg_addr_o = addr;
   assign hold_o     = rd_data && (addr == HOLD_A);

   // R7
   wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> (reg_addr_o <= LAST_A));

   // R9
   hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_o |-> !reg_wr_o);

   // R8
   oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_s) |=> !oe_int);
endmodule

// File: tb/tw_reg_port_tb_top.sv
module tw_reg_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_i = 1'b0;
   logic       sclk_i = 1'b0;
   logic       sdio_i = 1'b0;
   logic       sdio_o, sdio_oe, reg_wr_o, hold_o;
   logic [6:0] reg_addr_o;
   logic [7:0] reg_wdata_o, reg_rdata_i;

   int checks = 0;
   int errors = 0;
   int stb_cnt = 0;
   bit done = 1'b0;

   logic [7:0] bank [0:14];
   logic [7:0] exp_regs [0:14];
   logic [7:0] tx [0:7];
   logic [7:0] rx [0:7];
   logic [7:0] snap [0:7];
   logic       hold_seen [0:7];

   always #10 clk = ~clk;

   tw_reg_port dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_i        (cs_i),
      .sclk_i      (sclk_i),
      .sdio_i      (sdio_i),
      .sdio_o      (sdio_o),
      .sdio_oe     (sdio_oe),
      .reg_addr_o  (reg_addr_o),
      .reg_wr_o    (reg_wr_o),
      .reg_wdata_o (reg_wdata_o),
      .reg_rdata_i (reg_rdata_i),
      .hold_o      (hold_o)
   );

   // register bank model; location 14 behaves like a free-running sampled value
   assign reg_rdata_i = (reg_addr_o <= 7'd14) ? bank[reg_addr_o[3:0]] : 8'hA5;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 15; i++) bank[i] <= 8'h00;
      end else begin
         if (!hold_o) bank[14] <= bank[14] + 8'd1;
         if (reg_wr_o && reg_addr_o <= 7'd14) bank[reg_addr_o[3:0]] <= reg_wdata_o;
      end
   end

   always @(posedge clk) if (reg_wr_o) stb_cnt <= stb_cnt + 1;

   function automatic logic [6:0] nxt(input logic [6:0] a);
      return (a == 7'd14) ? 7'd0 : a + 7'd1;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      sclk_i = 1'b0; sdio_i = b; wait_clk(4);
      sclk_i = 1'b1; wait_clk(4);
   endtask

   // one transfer; partial > 0 appends that many extra bits of a dangling write byte
   task automatic xfer(input logic wr, input logic [6:0] a, input int nb, input int partial);
      logic [7:0] cmd;
      logic [6:0] cur;
      cmd = {wr, a};
      cur = a;
      cs_i = 1'b1; wait_clk(4);
      for (int i = 0; i < 8; i++) send_bit(cmd[i]);
      for (int b = 0; b < nb; b++) begin
         if (wr) begin
            for (int i = 0; i < 8; i++) send_bit(tx[b][i]);
         end else begin
            for (int i = 0; i < 8; i++) begin
               sclk_i = 1'b0; wait_clk(4);
               rx[b][i] = sdio_o;
               if (sdio_oe !== 1'b1) check("R4 oe", {31'd0, sdio_oe}, 32'd1);
               if (i == 4) begin
                  snap[b] = bank[14];
                  hold_seen[b] = hold_o;
               end
               sclk_i = 1'b1; wait_clk(4);
            end
         end
         cur = nxt(cur);
      end
      for (int i = 0; i < partial; i++) send_bit(1'b1);
      sclk_i = 1'b0; wait_clk(4);
      cs_i = 1'b0; wait_clk(8);
      check("R8 oe low", {31'd0, sdio_oe}, 32'd0);
      check("R9 hold low", {31'd0, hold_o}, 32'd0);
   endtask

   // write burst with model update and strobe count check
   task automatic do_write(input logic [6:0] a, input int nb, input string req);
      int s0, exp_stb;
      logic [6:0] cur;
      s0 = stb_cnt; exp_stb = 0; cur = a;
      xfer(1'b1, a, nb, 0);
      for (int b = 0; b < nb; b++) begin
         if (cur <= 7'd14) begin
            exp_stb++;
            if (cur < 7'd14) exp_regs[cur[3:0]] = tx[b];
         end
         cur = nxt(cur);
      end
      check(req, stb_cnt - s0, exp_stb);
   endtask

   task automatic do_read(input logic [6:0] a, input int nb);
      logic [6:0] cur;
      logic [7:0] e;
      cur = a;
      xfer(1'b0, a, nb, 0);
      for (int b = 0; b < nb; b++) begin
         if (cur == 7'd14) begin
            check("R9 snapshot", rx[b], snap[b]);
            check("R9 hold high", {31'd0, hold_seen[b]}, 32'd1);
         end else begin
            e = (cur < 7'd14) ? exp_regs[cur[3:0]] : 8'h00;
            if (cur > 7'd14) check("R7 reserved read", rx[b], e);
            else if (b == 0) check("R4 first byte", rx[b], e);
            else check("R5 burst byte", rx[b], e);
            check("R9 hold off", {31'd0, hold_seen[b]}, 32'd0);
         end
         cur = nxt(cur);
      end
   endtask

   initial begin
      int unsigned seed;
      for (int i = 0; i < 15; i++) exp_regs[i] = 8'h00;
      wait_clk(5);
      check("R10 oe", {31'd0, sdio_oe}, 32'd0);
      check("R10 wr", {31'd0, reg_wr_o}, 32'd0);
      check("R10 hold", {31'd0, hold_o}, 32'd0);
      rst_n = 1'b1;
      wait_clk(5);

      // R1 R2: single write then read back
      tx[0] = 8'h5C;
      do_write(7'd3, 1, "R2 single");
      do_read(7'd3, 1);
      // R1: direction bit clear gives no strobe
      begin
         int s0;
         s0 = stb_cnt;
         xfer(1'b0, 7'd3, 1, 0);
         check("R1 read no strobe", stb_cnt - s0, 0);
         check("R1 read data", rx[0], 8'h5C);
      end
      // R6: write and read across the wrap point
      tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
      do_write(7'd13, 4, "R6 wrap write");
      do_read(7'd13, 4);
      // R3: partial byte discarded
      begin
         int s0;
         s0 = stb_cnt;
         xfer(1'b1, 7'd3, 0, 5);
         check("R3 no strobe", stb_cnt - s0, 0);
         do_read(7'd3, 1);
      end
      // R7: reserved writes and reads, 0x7F rolls to 0x00
      tx[0] = 8'hFF; tx[1] = 8'hEE;
      do_write(7'h20, 2, "R7 reserved write");
      do_read(7'h7F, 2);
      // R9: read the sampled register
      do_read(7'd14, 2);

      // random mix
      seed = $urandom(32'd1234);
      for (int t = 0; t < 24; t++) begin
         logic       wr;
         logic [6:0] a;
         int         nb;
         wr = 1'($urandom % 2);
         a  = 7'($urandom % 20);
         nb = 1 + int'($urandom % 4);
         for (int b = 0; b < nb; b++) tx[b] = 8'($urandom);
         if (wr) do_write(a, nb, "R5 random write");
         else    do_read(a, nb);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule